// File: doc/BRIEF.md
# Calendar Alarm Comparator with Latched Interrupt

This block holds a full calendar alarm: seconds, minutes, hours, day, month and year, each stored as an 8-bit BCD byte. The bytes use the same encoding as the running calendar. The calendar counter lives outside the block. It presents its six live fields on a packed input and pulses `tick` once per second. On each accepted tick the block captures the live calendar into a snapshot. A small state machine then walks the six fields one per cycle and compares each against the stored alarm byte. It leaves the walk early on the first mismatch. When all six fields agree, it sets a sticky alarm flag.

Software reaches the block through a simple register port: one address bus, a write strobe, write data and a combinational read-back. An enable register gates the flag onto an active-low, level interrupt line. The flag is cleared by writing a one to its bit, so writing back a value just read clears whatever was pending. Before rewriting the alarm bytes, software is expected to clear the enable, then set it again afterwards if wanted.

The scan state machine has three states. IDLE waits for a tick. SCAN compares one field per cycle. HIT sets the flag. The transitions are:
- START: IDLE to SCAN on a tick, loading the snapshot and pointing at the seconds field.
- STEP: SCAN to SCAN when a field agrees and it is not the last one.
- MISS: SCAN to IDLE on any disagreeing field.
- FULL: SCAN to HIT when the year field agrees.
- RETIRE: HIT to IDLE after one cycle.

Top module: `cal_alarm`

## Requirements
- R1: After reset, all six alarm bytes read 0x00, the enable reads 0x00, the flag reads 0x00, and `irq_n` is 1.
- R2: Addresses 0 to 5 hold the alarm bytes in the order seconds, minutes, hours, day, month, year, and read back exactly what was written. Address 6 holds the enable in bit 0. Address 7 holds the flag in bit 0. Unused bits of addresses 6 and 7 read 0.
- R3: In `cal_now`, field k sits at bits [8k+7:8k], with seconds at k=0 and year at k=5. When every field equals its alarm byte at an accepted tick, the flag reads 1 exactly 7 clock edges after the edge that samples the tick, and not after 6.
- R4: If any single field differs from its alarm byte at the tick, the flag stays 0.
- R5: Once set, the flag stays set until cleared, whatever the enable and any later non-matching ticks.
- R6: `irq_n` is 0 exactly when the flag is 1 and the enable bit is 1; it is a level, not a pulse.
- R7: A write to address 7 with bit 0 set clears the flag. A write to address 7 with bit 0 clear leaves it unchanged.
- R8: If the flag-setting cycle coincides with a clearing write to address 7, the flag ends set.
- R9: The comparison uses the calendar captured at the tick. Later changes on `cal_now` do not affect the result, and a tick arriving while a scan is running is ignored. Ticks must be at least 8 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per calendar second |
| cal_now | input | 48 | Live BCD calendar, seconds in the low byte, year in the high byte |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_n | output | 1 | Active-low level alarm interrupt |

## Verification
The hardest situation to reach from the ports is a flag-clearing write that lands in the very cycle the scan finishes with a full match. The bench reaches it by counting: it pulses a matching tick, waits exactly six edges, and then drives the clearing write so that the seventh edge samples both the hit and the write. Two further cases need the same timing control. One changes the live calendar right after the tick, to show that the snapshot is used. The other injects a second tick mid-scan, to show that it is dropped.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_HIT   = 2'd2
    } scan_state_t;

endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs #(
    parameter int FIELDS = 6,
    parameter int FW     = 8,
    parameter int AW     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [FW-1:0]        wdata,
    input  logic                 flag,
    output logic [FIELDS*FW-1:0] alarm_vec,
    output logic                 irq_en,
    output logic                 clr_req,
    output logic [FW-1:0]        rdata
);
    localparam int ADDR_EN   = FIELDS;
    localparam int ADDR_STAT = FIELDS + 1;

    logic [FW-1:0] alarm_q [FIELDS];
    logic          en_q;

    // one byte register per alarm field, address equals field index
    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                alarm_q[g] <= '0;
            else if (wr_en && addr == AW'(g))
                alarm_q[g] <= wdata;
        end
        assign alarm_vec[g*FW +: FW] = alarm_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (wr_en && addr == AW'(ADDR_EN))
            en_q <= wdata[0];
    end

    assign irq_en  = en_q;
    assign clr_req = wr_en && (addr == AW'(ADDR_STAT)) && wdata[0];

    always_comb begin
        rdata = '0;
        for (int i = 0; i < FIELDS; i++) begin
            if (addr == AW'(i))
                rdata = alarm_q[i];
        end
        if (addr == AW'(ADDR_EN))
            rdata = {{(FW-1){1'b0}}, en_q};
        if (addr == AW'(ADDR_STAT))
            rdata = {{(FW-1){1'b0}}, flag};
    end

endmodule

// File: rtl/cal_alarm_scan.sv
module cal_alarm_scan
    import cal_alarm_pkg::*;
#(
    parameter int FIELDS = 6,
    parameter int FW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [FIELDS*FW-1:0] cal_now,
    input  logic [FIELDS*FW-1:0] alarm_vec,
    output scan_state_t          state,
    output logic [FIELDS*FW-1:0] snap,
    output logic                 hit
);
    localparam int IW = (FIELDS > 1) ? $clog2(FIELDS) : 1;
    localparam logic [IW-1:0] LAST = IW'(FIELDS - 1);

    scan_state_t        st_q, st_d;
    logic [IW-1:0]      idx_q, idx_d;
    logic [FIELDS*FW-1:0] snap_q;
    logic               load;
    logic [FW-1:0]      snap_f  [FIELDS];
    logic [FW-1:0]      alarm_f [FIELDS];
    logic               same;

    for (genvar g = 0; g < FIELDS; g++) begin : g_view
        assign snap_f[g]  = snap_q[g*FW +: FW];
        assign alarm_f[g] = alarm_vec[g*FW +: FW];
    end

    always_comb begin
        same = 1'b0;
        for (int i = 0; i < FIELDS; i++) begin
            if (idx_q == IW'(i))
                same = (snap_f[i] == alarm_f[i]);
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        load  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (tick) begin
                    st_d  = ST_SCAN;
                    idx_d = '0;
                    load  = 1'b1;
                end
            end
            ST_SCAN: begin
                if (!same)
                    st_d = ST_IDLE;
                else if (idx_q == LAST)
                    st_d = ST_HIT;
                else
                    idx_d = idx_q + IW'(1);
            end
            ST_HIT: begin
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            snap_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
            if (load)
                snap_q <= cal_now;
        end
    end

    // outputs
    always_comb begin
        state = st_q;
        snap  = snap_q;
        hit   = (st_q == ST_HIT);
    end

endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr_req,
    input  logic irq_en,
    output logic flag,
    output logic irq_n
);
    logic flag_q;

    // a set event has priority over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (clr_req)
            flag_q <= 1'b0;
    end

    assign flag  = flag_q;
    assign irq_n = ~(flag_q & irq_en);

endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
    import cal_alarm_pkg::*;
#(
    parameter int FIELDS = 6,
    parameter int FW     = 8,
    parameter int AW     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [FIELDS*FW-1:0] cal_now,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [FW-1:0]        wdata,
    output logic [FW-1:0]        rdata,
    output logic                 irq_n
);
    logic [FIELDS*FW-1:0] alarm_vec;
    logic                 irq_en;
    logic                 clr_req;
    logic                 flag;
    logic                 hit;
    scan_state_t          st;
    logic [FIELDS*FW-1:0] snap;

    cal_alarm_regs #(.FIELDS(FIELDS), .FW(FW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .flag      (flag),
        .alarm_vec (alarm_vec),
        .irq_en    (irq_en),
        .clr_req   (clr_req),
        .rdata     (rdata)
    );

    cal_alarm_scan #(.FIELDS(FIELDS), .FW(FW)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cal_now   (cal_now),
        .alarm_vec (alarm_vec),
        .state     (st),
        .snap      (snap),
        .hit       (hit)
    );

    cal_alarm_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr_req (clr_req),
        .irq_en  (irq_en),
        .flag    (flag),
        .irq_n   (irq_n)
    );

endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk
    import cal_alarm_pkg::*;
#(
    parameter int FIELDS = 6,
    parameter int FW     = 8,
    parameter int AW     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [AW-1:0]        addr,
    input logic [FW-1:0]        wdata,
    input logic                 irq_n,
    input scan_state_t          st,
    input logic [FIELDS*FW-1:0] snap,
    input logic                 flag,
    input logic                 irq_en
);
    logic clr_wr;
    assign clr_wr = wr_en && (addr == AW'(FIELDS + 1)) && wdata[0];

    a_r3_set_after_full_scan: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(st == ST_HIT));

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_wr) |=> flag);

    a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !(flag && irq_en));

    a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && st != ST_HIT) |=> !flag);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HIT) |=> flag);

    a_r9_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SCAN) |=> $stable(snap));

endmodule

bind cal_alarm cal_alarm_chk #(.FIELDS(FIELDS), .FW(FW), .AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .irq_n  (irq_n),
    .st     (st),
    .snap   (snap),
    .flag   (flag),
    .irq_en (irq_en)
);

// File: tb/test_cal_alarm.sv
`timescale 1ns/1ps
module test_cal_alarm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [47:0] cal_now = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [47:0] ALM = {8'h99, 8'h12, 8'h31, 8'h23, 8'h30, 8'h45};

    always #2.5 clk = ~clk;

    cal_alarm i_cal_alarm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cal_now(cal_now),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_alarm();
        for (int i = 0; i < 6; i++) wr(3'(i), ALM[i*8 +: 8]);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            check("R1 reset register", v, 8'h00);
        end
        check("R1 reset irq_n", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        load_alarm();
        for (int i = 0; i < 6; i++) begin
            rd(3'(i), v);
            check("R2 alarm byte readback", v, ALM[i*8 +: 8]);
        end
        wr(3'd6, 8'hFF);
        rd(3'd6, v);
        check("R2 enable reads bit0 only", v, 8'h01);
        wr(3'd6, 8'h00);
        rd(3'd6, v);
        check("R2 enable cleared", v, 8'h00);
    endtask

    task automatic t_match_latency();
        logic [7:0] v;
        cal_now = ALM;
        pulse_tick();
        wait_cyc(6);
        rd(3'd7, v);
        check("R3 flag not yet set after 6 edges", v, 8'h00);
        wait_cyc(1);
        rd(3'd7, v);
        check("R3 flag set after 7 edges", v, 8'h01);
        wr(3'd7, 8'h01);
    endtask

    task automatic t_single_miss();
        logic [7:0] v;
        for (int f = 0; f < 6; f++) begin
            cal_now = ALM;
            cal_now[f*8 +: 8] = ALM[f*8 +: 8] ^ 8'h01;
            pulse_tick();
            wait_cyc(10);
            rd(3'd7, v);
            check("R4 single field mismatch gives no flag", v, 8'h00);
        end
    endtask

    task automatic t_sticky_irq();
        logic [7:0] v;
        cal_now = ALM;
        pulse_tick();
        wait_cyc(10);
        check("R6 irq high while disabled", {7'd0, irq_n}, 8'h01);
        wr(3'd6, 8'h01);
        check("R6 irq low when enabled and flagged", {7'd0, irq_n}, 8'h00);
        wait_cyc(20);
        check("R6 irq stays low as a level", {7'd0, irq_n}, 8'h00);
        cal_now = ALM ^ 48'h1;
        pulse_tick();
        wait_cyc(10);
        rd(3'd7, v);
        check("R5 non-matching tick keeps flag", v, 8'h01);
        wr(3'd6, 8'h00);
        rd(3'd7, v);
        check("R5 flag kept with enable off", v, 8'h01);
        check("R6 irq high after disable", {7'd0, irq_n}, 8'h01);
        wr(3'd6, 8'h01);
        check("R6 irq low again", {7'd0, irq_n}, 8'h00);
    endtask

    task automatic t_clear();
        logic [7:0] v;
        wr(3'd7, 8'h00);
        rd(3'd7, v);
        check("R7 zero write keeps flag", v, 8'h01);
        wr(3'd7, 8'hFE);
        rd(3'd7, v);
        check("R7 bit0-clear write keeps flag", v, 8'h01);
        wr(3'd7, 8'h01);
        rd(3'd7, v);
        check("R7 one write clears flag", v, 8'h00);
        check("R6 irq high after clear", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        cal_now = ALM;
        pulse_tick();
        wait_cyc(6);
        wr_en = 1'b1; addr = 3'd7; wdata = 8'h01;
        @(negedge clk);
        wr_en = 1'b0;
        rd(3'd7, v);
        check("R8 set beats same-cycle clear", v, 8'h01);
        wr(3'd7, 8'h01);
        rd(3'd7, v);
        check("R8 later clear works", v, 8'h00);
    endtask

    task automatic t_snapshot();
        logic [7:0] v;
        cal_now = ALM;
        pulse_tick();
        cal_now = ALM ^ 48'hFF_0000_0000_00;
        wait_cyc(10);
        rd(3'd7, v);
        check("R9 post-tick change does not block match", v, 8'h01);
        wr(3'd7, 8'h01);
        cal_now = ALM ^ 48'h01_0000_0000_00;
        pulse_tick();
        cal_now = ALM;
        wait_cyc(10);
        rd(3'd7, v);
        check("R9 post-tick change does not create match", v, 8'h00);
        cal_now = ALM ^ 48'h01_0000_0000_00;
        pulse_tick();
        cal_now = ALM;
        wait_cyc(2);
        pulse_tick();
        wait_cyc(12);
        rd(3'd7, v);
        check("R9 tick during scan ignored", v, 8'h00);
    endtask

    initial begin
        wait_cyc(3);
        t_reset();
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_regmap();
        t_match_latency();
        t_single_miss();
        t_sticky_irq();
        t_clear();
        t_set_wins();
        t_snapshot();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule